// File: doc/BRIEF.md
# EDID Segment and Offset Tracker

This block sits in front of an I2C-over-AUX request path. It watches each request the host side issues. A host EDID driver sets the segment pointer by writing to the segment-pointer address (0x30). It sets the read offset by writing to the EDID address (0x50). Some sinks mishandle the middle-of-transaction flag. On these sinks, a continued read inside an EDID block can return bytes from the wrong place. The tracker fixes this before each such read. It inserts short helper writes that restate the current segment and offset. It then lets the original read continue.

The block keeps two 8-bit registers: the captured segment and the running offset. Each read that qualifies moves the offset forward by 16. When the offset reaches a 128-byte block boundary, the segment returns to zero.

The output is one stream of request descriptors, accepted by `out_ready`. Each descriptor carries an address, a data byte, a size and control flags. Helper writes are marked. While helpers are in flight, the original request is held with `req_stall`. After the helpers, the original request goes out unchanged.

Top module: `edid_seg_tracker`

## Requirements
- R1: After reset the segment and the offset are both zero, `out_valid` is low and `req_stall` is low while no request is offered.
- R2: An accepted I2C write (`req_native`=0, `req_read`=0) with non-zero size to address 0x30 loads its data byte into the segment. One to address 0x50 loads its data byte into the offset. Native requests, reads and zero-size requests load neither register.
- R3: A request qualifies only when it is an I2C read with `req_mot`=1 and non-zero size. Other requests are forwarded at once, with no helper writes and no change to the offset.
- R4: A qualifying read gets no helper writes when the low 7 bits of the offset are zero.
- R5: A qualifying read with a non-zero low offset part gets helpers in this order. First, if the segment is non-zero, a write of the segment to address 0x30. Then a write of the offset to the read's own address.
- R6: Every helper descriptor has `out_inject`=1, `out_skip_addr`=1, `out_skip_stop`=1, `out_read`=0, `out_native`=0, `out_mot`=0 and `out_size`=1.
- R7: When a qualifying read is forwarded, the offset grows by 16, modulo 256.
- R8: When that growth makes the offset 0x80 or 0x00, the segment is cleared to zero in the same update.
- R9: While helpers are pending, `req_stall` is high. The original request is forwarded afterwards with every field unchanged, and with `out_inject`, `out_skip_addr` and `out_skip_stop` all low. When a request is being forwarded, `req_stall` equals the inverse of `out_ready`.
- R10: A descriptor presented while `out_ready` is low stays valid and keeps its contents until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_native | input | 1 | 1 = native request, 0 = I2C-over-AUX |
| req_read | input | 1 | 1 = read, 0 = write |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | First data byte of a write |
| req_size | input | SIZE_W | Byte count |
| req_stall | output | 1 | Hold the incoming request |
| out_ready | input | 1 | Downstream accepts the current descriptor |
| out_valid | output | 1 | Descriptor present |
| out_native | output | 1 | Descriptor native flag |
| out_read | output | 1 | Descriptor read flag |
| out_mot | output | 1 | Descriptor middle-of-transaction flag |
| out_addr | output | ADDR_W | Descriptor address |
| out_data | output | DATA_W | Descriptor data byte |
| out_size | output | SIZE_W | Descriptor byte count |
| out_skip_addr | output | 1 | Send without the address phase |
| out_skip_stop | output | 1 | Send without a stop |
| out_inject | output | 1 | Descriptor is a helper write |

## Verification
Two updates can land on the same register write: the offset growing by 16 and the segment being cleared. This happens when a qualifying read moves the offset onto 0x80, or wraps it to 0x00. The bench reaches both cases by loading a non-zero segment and an offset of 0x70 or 0xF0, then issuing continued reads. The first read must still carry the segment helper. The next read must show the new offset and no segment helper. Downstream backpressure is applied during helper sequences, so a stalled helper must wait in place while the original request is held.

// File: rtl/edid_trk_pkg.sv
package edid_trk_pkg;

    typedef enum logic [1:0] {
        PH_PASS = 2'd0,
        PH_OFF  = 2'd1,
        PH_FWD  = 2'd2
    } phase_e;

    function automatic logic is_cont_read(input logic native, input logic rd,
                                          input logic mot, input logic size_nz);
        return !native && rd && mot && size_nz;
    endfunction

    function automatic logic is_i2c_write(input logic native, input logic rd,
                                          input logic size_nz);
        return !native && !rd && size_nz;
    endfunction

endpackage

// File: rtl/edid_ptr_regs.sv
module edid_ptr_regs
    import edid_trk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int OFF_W     = 8,
    parameter int STEP      = 16,
    parameter int BLOCK_LEN = 128,
    parameter int SEG_ADDR  = 'h30,
    parameter int EDID_ADDR = 'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              qual,
    input  logic              wr_cap,
    input  logic [ADDR_W-1:0] addr,
    input  logic [OFF_W-1:0]  data,
    output logic [OFF_W-1:0]  seg_q,
    output logic [OFF_W-1:0]  off_q,
    output logic              aligned
);
    localparam int BLK_BITS = $clog2(BLOCK_LEN);
    localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);
    localparam logic [OFF_W-1:0] BND_A  = OFF_W'(BLOCK_LEN);
    localparam logic [OFF_W-1:0] BND_B  = OFF_W'((2 * BLOCK_LEN) % (1 << OFF_W));

    typedef struct packed {
        logic [OFF_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [OFF_W-1:0] off_next;

    always_comb begin
        st_d     = st_q;
        off_next = st_q.off + STEP_V;
        if (fire) begin
            if (qual) begin
                st_d.off = off_next;
                if (off_next == BND_A || off_next == BND_B)
                    st_d.seg = '0;
            end else if (wr_cap) begin
                if (addr == ADDR_W'(SEG_ADDR))
                    st_d.seg = data;
                else if (addr == ADDR_W'(EDID_ADDR))
                    st_d.off = data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg_q   = st_q.seg;
    assign off_q   = st_q.off;
    assign aligned = (st_q.off[BLK_BITS-1:0] == '0);

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && qual |=> off_q == $past(off_q) + STEP_V);

    assert_seg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && qual && ((off_q + STEP_V == BND_A) || (off_q + STEP_V == BND_B))
        |=> seg_q == '0);

    assert_native_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(seg_q) && $stable(off_q));
endmodule

// File: rtl/edid_inject_fsm.sv
module edid_inject_fsm
    import edid_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic qual,
    input  logic aligned,
    input  logic seg_nz,
    input  logic out_ready,
    output logic emit_seg,
    output logic emit_off,
    output logic fwd,
    output logic stall,
    output logic fwd_fire
);
    typedef struct packed {
        phase_e ph;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        emit_seg = 1'b0;
        emit_off = 1'b0;
        fwd      = 1'b0;
        stall    = 1'b0;
        unique case (st_q.ph)
            PH_PASS: begin
                if (req_valid) begin
                    if (qual && !aligned) begin
                        stall = 1'b1;
                        if (seg_nz) begin
                            emit_seg = 1'b1;
                            if (out_ready) st_d.ph = PH_OFF;
                        end else begin
                            emit_off = 1'b1;
                            if (out_ready) st_d.ph = PH_FWD;
                        end
                    end else begin
                        fwd   = 1'b1;
                        stall = !out_ready;
                    end
                end
            end
            PH_OFF: begin
                stall    = 1'b1;
                emit_off = 1'b1;
                if (out_ready) st_d.ph = PH_FWD;
            end
            PH_FWD: begin
                fwd   = 1'b1;
                stall = !out_ready;
                if (req_valid && out_ready) st_d.ph = PH_PASS;
            end
            default: st_d.ph = PH_PASS;
        endcase
        fwd_fire = fwd && req_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_PASS};
        else        st_q <= st_d;
    end

    assert_aligned_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph == PH_PASS && req_valid && qual && aligned |-> !emit_seg && !emit_off);

    assert_seg_then_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        emit_seg && out_ready |=> emit_off);

    assert_fwd_after_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        emit_off && out_ready |=> fwd && !emit_seg);
endmodule

// File: rtl/edid_req_mux.sv
module edid_req_mux #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int SIZE_W   = 8,
    parameter int SEG_ADDR = 'h30
) (
    input  logic              emit_seg,
    input  logic              emit_off,
    input  logic              fwd,
    input  logic              req_valid,
    input  logic              req_native,
    input  logic              req_read,
    input  logic              req_mot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] seg_val,
    input  logic [DATA_W-1:0] off_val,
    output logic              out_valid,
    output logic              out_native,
    output logic              out_read,
    output logic              out_mot,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [SIZE_W-1:0] out_size,
    output logic              out_skip_addr,
    output logic              out_skip_stop,
    output logic              out_inject
);
    logic helper;
    assign helper = emit_seg || emit_off;

    always_comb begin
        out_valid     = helper || (fwd && req_valid);
        out_native    = helper ? 1'b0 : req_native;
        out_read      = helper ? 1'b0 : req_read;
        out_mot       = helper ? 1'b0 : req_mot;
        out_size      = helper ? SIZE_W'(1) : req_size;
        out_skip_addr = helper;
        out_skip_stop = helper;
        out_inject    = helper;
        if (emit_seg) begin
            out_addr = ADDR_W'(SEG_ADDR);
            out_data = seg_val;
        end else if (emit_off) begin
            out_addr = req_addr;
            out_data = off_val;
        end else begin
            out_addr = req_addr;
            out_data = req_data;
        end
    end
endmodule

// File: rtl/edid_seg_tracker.sv
module edid_seg_tracker
    import edid_trk_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SIZE_W    = 8,
    parameter int STEP      = 16,
    parameter int BLOCK_LEN = 128,
    parameter int SEG_ADDR  = 'h30,
    parameter int EDID_ADDR = 'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_native,
    input  logic              req_read,
    input  logic              req_mot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SIZE_W-1:0] req_size,
    output logic              req_stall,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_native,
    output logic              out_read,
    output logic              out_mot,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [SIZE_W-1:0] out_size,
    output logic              out_skip_addr,
    output logic              out_skip_stop,
    output logic              out_inject
);
    logic size_nz, qual, wr_cap, aligned;
    logic emit_seg, emit_off, fwd, fwd_fire;
    logic [DATA_W-1:0] seg_q, off_q;

    assign size_nz = (req_size != '0);
    assign qual    = is_cont_read(req_native, req_read, req_mot, size_nz);
    assign wr_cap  = is_i2c_write(req_native, req_read, size_nz);

    edid_ptr_regs #(
        .ADDR_W(ADDR_W), .OFF_W(DATA_W), .STEP(STEP), .BLOCK_LEN(BLOCK_LEN),
        .SEG_ADDR(SEG_ADDR), .EDID_ADDR(EDID_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .fire(fwd_fire), .qual(qual), .wr_cap(wr_cap),
        .addr(req_addr), .data(req_data), .seg_q(seg_q), .off_q(off_q),
        .aligned(aligned)
    );

    edid_inject_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .qual(qual),
        .aligned(aligned), .seg_nz(seg_q != '0), .out_ready(out_ready),
        .emit_seg(emit_seg), .emit_off(emit_off), .fwd(fwd), .stall(req_stall),
        .fwd_fire(fwd_fire)
    );

    edid_req_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .SEG_ADDR(SEG_ADDR)
    ) u_mux (
        .emit_seg(emit_seg), .emit_off(emit_off), .fwd(fwd),
        .req_valid(req_valid), .req_native(req_native), .req_read(req_read),
        .req_mot(req_mot), .req_addr(req_addr), .req_data(req_data),
        .req_size(req_size), .seg_val(seg_q), .off_val(off_q),
        .out_valid(out_valid), .out_native(out_native), .out_read(out_read),
        .out_mot(out_mot), .out_addr(out_addr), .out_data(out_data),
        .out_size(out_size), .out_skip_addr(out_skip_addr),
        .out_skip_stop(out_skip_stop), .out_inject(out_inject)
    );

    assert_helper_format_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_inject |-> out_skip_addr && out_skip_stop && !out_read
                                    && !out_native && !out_mot && out_size == SIZE_W'(1));

    assert_helper_holds_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_inject |-> req_stall);

    assert_fwd_unchanged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_inject |-> out_addr == req_addr && out_data == req_data
                                     && out_size == req_size && req_stall == !out_ready);

    assert_backpressure_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_inject && !out_ready |=> out_valid && out_inject
                                                 && $stable(out_data) && $stable(out_addr));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !out_inject |-> !out_valid);
endmodule

// File: tb/edid_seg_tracker_bench.sv
module edid_seg_tracker_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       req_valid = 1'b0, req_native = 1'b0, req_read = 1'b0, req_mot = 1'b0;
    logic [7:0] req_addr = '0, req_data = '0, req_size = '0;
    logic       req_stall, out_ready = 1'b1;
    logic       out_valid, out_native, out_read, out_mot;
    logic [7:0] out_addr, out_data, out_size;
    logic       out_skip_addr, out_skip_stop, out_inject;

    edid_seg_tracker u_edid_seg_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_native(req_native),
        .req_read(req_read), .req_mot(req_mot), .req_addr(req_addr),
        .req_data(req_data), .req_size(req_size), .req_stall(req_stall),
        .out_ready(out_ready), .out_valid(out_valid), .out_native(out_native),
        .out_read(out_read), .out_mot(out_mot), .out_addr(out_addr),
        .out_data(out_data), .out_size(out_size), .out_skip_addr(out_skip_addr),
        .out_skip_stop(out_skip_stop), .out_inject(out_inject)
    );

    typedef struct {
        logic [32:0] fields;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int checks = 0, errors = 0;
    int seg_m = 0, off_m = 0;
    bit bp = 1'b0;
    int tick = 0;
    bit finished = 1'b0;

    function automatic logic [32:0] pack(logic n, logic r, logic m, logic [7:0] a,
                                         logic [7:0] d, logic [7:0] s,
                                         logic sa, logic ss, logic inj);
        return {n, r, m, a, d, s, sa, ss, inj};
    endfunction

    task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every accepted descriptor
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            logic [32:0] act;
            act = pack(out_native, out_read, out_mot, out_addr, out_data, out_size,
                       out_skip_addr, out_skip_stop, out_inject);
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected descriptor", act, '0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(act == it.fields, it.tag, act, it.fields);
            end
        end
    end

    // driver: model updates and request handshake
    task automatic send(logic n, logic r, logic m, logic [7:0] a, logic [7:0] d,
                        logic [7:0] s, string tag);
        bit qual, acc;
        qual = !n && r && m && (s != 0);
        if (qual && (off_m % 128) != 0) begin
            if (seg_m != 0)
                exp_q.push_back('{pack(0, 0, 0, 8'h30, 8'(seg_m), 8'd1, 1, 1, 1), "R5"});
            exp_q.push_back('{pack(0, 0, 0, a, 8'(off_m), 8'd1, 1, 1, 1), "R6"});
        end
        exp_q.push_back('{pack(n, r, m, a, d, s, 0, 0, 0), tag});
        if (qual) begin
            off_m = (off_m + 16) % 256;            // R7
            if (off_m == 'h80 || off_m == 0) seg_m = 0; // R8
        end else if (!n && !r && s != 0) begin      // R2
            if (a == 8'h30) seg_m = d;
            else if (a == 8'h50) off_m = d;
        end
        @(negedge clk);
        req_valid = 1; req_native = n; req_read = r; req_mot = m;
        req_addr = a; req_data = d; req_size = s;
        do begin
            tick++;
            out_ready = bp ? ((tick % 3) == 0) : 1'b1;
            #1;
            acc = !req_stall;
            @(negedge clk);
        end while (!acc);
        req_valid = 0;
        out_ready = 1'b1;
    endtask

    task automatic drain(string tag);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, tag, 33'(exp_q.size()), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && !req_stall, "R1 reset quiet",
              33'({out_valid, req_stall}), '0);
        // R1 zero segment/offset: aligned start, continued read gets no helper
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R1");
        // R2 offset capture, then R5/R6 offset helper
        send(0, 0, 0, 8'h50, 8'h10, 8'd1, "R2");
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R9");
        // R3 read without continuation flag, and zero-size read
        send(0, 1, 0, 8'h50, 8'h00, 8'd16, "R3");
        send(0, 1, 1, 8'h50, 8'h00, 8'd0, "R3");
        // R2 native write and zero-size write ignored
        send(1, 0, 0, 8'h50, 8'h33, 8'd1, "R2");
        send(0, 0, 0, 8'h30, 8'h07, 8'd0, "R2");
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R9");
        // R5 segment then offset, with backpressure (R10)
        send(0, 0, 0, 8'h30, 8'h02, 8'd1, "R2");
        send(0, 0, 0, 8'h50, 8'h60, 8'd1, "R2");
        bp = 1'b1;
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R10");
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R8");
        bp = 1'b0;
        // R4 now aligned at 0x80, then offset-only helper at 0x90
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R4");
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R7");
        // R8 wrap to zero clears segment
        send(0, 0, 0, 8'h30, 8'h01, 8'd1, "R2");
        send(0, 0, 0, 8'h50, 8'hF0, 8'd1, "R2");
        bp = 1'b1;
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R8");
        bp = 1'b0;
        send(0, 1, 1, 8'h50, 8'h00, 8'd16, "R4");
        // helper to a non-EDID read address carries the read's address (R5)
        send(0, 0, 0, 8'h50, 8'h24, 8'd1, "R2");
        send(0, 1, 1, 8'h52, 8'h00, 8'd8, "R5");
        drain("R9 scoreboard empty");
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule